// File: doc/BRIEF.md
# DMA Channel Enable and Request Control

This block holds the control state for a pair of DMA channels and decides when each one asks a separate transfer engine to move a unit of data. Software programs each channel through a small register port. The programmable state is an enable flag, two direction flags, a request-source code, a source address, a destination address and a counter reload value. Writing the enable flag as 1 loads the channel's working pointer and working transfer counter from those registers. This happens even when the channel is already enabled.

Requests come from software, by writing a trigger bit together with source code 0. They can also come from one of the peripheral interrupt-request lines, picked by the source code. Every request sets a pending flag, whether or not the channel is enabled. An enabled channel that is idle turns a pending request into a one-cycle start strobe and clears the flag in that same step. The engine answers with a done pulse. The done pulse steps the counter down and, when a forward direction is chosen, steps the pointer up. Software can clear the pending flag but can never set it. Because the block tracks the level of the selected line, changing the source code while the newly chosen line is high raises a request.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset, every readable register of both channels reads 0 and no start strobe is driven.
- R2: A control write (address 0) with bit 0 = 1 loads the working counter (address 6) from the reload register (address 4). This also holds when the channel is already enabled.
- R3: The same write loads the working pointer (address 5) from the source address (address 2) when its bit 2 is 1. Otherwise it loads from the destination address (address 3) when its bit 3 is 1. With both bits 0, the pointer keeps its value.
- R4: While enable, pending (control bit 1) and not-busy all hold, the start strobe for that channel is high. One cycle later the strobe is low and pending reads 0, unless a new request arrived in that cycle.
- R5: A request on a disabled channel sets pending. Pending then stays at 1 and no start strobe is issued.
- R6: Writing control bit 1 as 0 clears pending. Writing it as 1 leaves pending unchanged.
- R7: A select write (address 1) with bits [4:0] = 0 and bit 5 = 1 is a software request. Bit 5 is ignored when bits [4:0] are nonzero, and bit 5 always reads back as 0.
- R8: With a nonzero source code s, a rising edge on line s of the peripheral request vector sets pending. Other lines have no effect, and a line held high yields only one request.
- R9: Changing the source code to a line that is currently high sets pending.
- R10: After a start, the channel is busy and issues no new start. A done pulse ends busy, lowers the counter by 1, and raises the pointer by 1 if bit 2 or bit 3 was set in the last control write.
- R11: When a request arrives in the same cycle as a control write that sets enable and clears pending, pending ends at 1 and the reload still happens.
- R12: The two channels are independent: requests, writes and done pulses on one channel leave the other channel's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | DW | Write data |
| rd_ch | input | CHW | Channel addressed by the read |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | DW | Combinational read data |
| per_req | input | 2**(SELW+1) | Peripheral interrupt-request levels |
| xfer_start | output | NCH | One strobe per channel to the transfer engine |
| xfer_done | input | NCH | Transfer-complete pulse per channel |

## Verification
The hardest case to reach is R11, where a peripheral edge and a control write hit the same clock edge. The bench holds the write signals and raises the selected request line at the same falling edge, so both are seen by one rising edge. It then checks the start strobe, the counter and the pointer on the next cycle. The source-selection behaviour is swept over every nonzero source code against every request line. A separate step switches the selection onto a line already held high, to show the spurious request of R9.

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
  parameter int NCH  = 2,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 16,
  parameter int SELW = 4,
  localparam int NSRC = 2 ** (SELW + 1),
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CHW-1:0]  wr_ch,
  input  logic [2:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [CHW-1:0]  rd_ch,
  input  logic [2:0]      rd_addr,
  output logic [DW-1:0]   rd_data,
  input  logic [NSRC-1:0] per_req,
  output logic [NCH-1:0]  xfer_start,
  input  logic [NCH-1:0]  xfer_done
);
  localparam logic [2:0] A_CTRL = 3'd0, A_SEL = 3'd1, A_SAR = 3'd2, A_DAR = 3'd3,
                         A_RLD  = 3'd4, A_PTR = 3'd5, A_CNT = 3'd6;

  logic [NCH-1:0]    en_v, pend_v, busy_v, evt_v;
  logic [NCH*CW-1:0] cnt_v, rld_v;
  logic [DW-1:0]     ch_rd [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          en_q, pend_q, sfwd_q, dfwd_q, busy_q, lvl_q;
    logic [SELW:0] src_q;
    logic [AW-1:0] sar_q, dar_q, ptr_q;
    logic [CW-1:0] rld_q, cnt_q;

    wire hit    = wr_en && (wr_ch == CHW'(c));
    wire w_ctrl = hit && wr_addr == A_CTRL;
    wire w_sel  = hit && wr_addr == A_SEL;
    wire reload = w_ctrl && wr_data[0];
    wire sw_evt = w_sel && wr_data[SELW:0] == '0 && wr_data[SELW+1];
    wire lvl    = per_req[src_q];
    wire pe_evt = (src_q != '0) && lvl && !lvl_q;
    wire evt    = sw_evt || pe_evt;
    wire start  = en_q && pend_q && !busy_q;
    wire fin    = xfer_done[c] && busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= 1'b0; pend_q <= 1'b0; sfwd_q <= 1'b0; dfwd_q <= 1'b0;
        busy_q <= 1'b0; lvl_q <= 1'b0; src_q <= '0;
        sar_q <= '0; dar_q <= '0; ptr_q <= '0; rld_q <= '0; cnt_q <= '0;
      end else begin
        lvl_q <= lvl;
        if (evt)                          pend_q <= 1'b1;
        else if (start)                   pend_q <= 1'b0;
        else if (w_ctrl && !wr_data[1])   pend_q <= 1'b0;
        if (w_ctrl) begin
          en_q   <= wr_data[0];
          sfwd_q <= wr_data[2];
          dfwd_q <= wr_data[3];
        end
        if (w_sel)                   src_q <= wr_data[SELW:0];
        if (hit && wr_addr == A_SAR) sar_q <= wr_data[AW-1:0];
        if (hit && wr_addr == A_DAR) dar_q <= wr_data[AW-1:0];
        if (hit && wr_addr == A_RLD) rld_q <= wr_data[CW-1:0];
        if (start)    busy_q <= 1'b1;
        else if (fin) busy_q <= 1'b0;
        if (reload) begin
          cnt_q <= rld_q;
          if (wr_data[2])      ptr_q <= sar_q;
          else if (wr_data[3]) ptr_q <= dar_q;
        end else if (fin) begin
          cnt_q <= cnt_q - 1'b1;
          if (sfwd_q || dfwd_q) ptr_q <= ptr_q + 1'b1;
        end
      end
    end

    assign xfer_start[c] = start;
    assign en_v[c]   = en_q;
    assign pend_v[c] = pend_q;
    assign busy_v[c] = busy_q;
    assign evt_v[c]  = evt;
    assign cnt_v[c*CW +: CW] = cnt_q;
    assign rld_v[c*CW +: CW] = rld_q;

    assign ch_rd[c] = (rd_addr == A_CTRL) ? DW'({dfwd_q, sfwd_q, pend_q, en_q}) :
                      (rd_addr == A_SEL)  ? DW'(src_q) :
                      (rd_addr == A_SAR)  ? DW'(sar_q) :
                      (rd_addr == A_DAR)  ? DW'(dar_q) :
                      (rd_addr == A_RLD)  ? DW'(rld_q) :
                      (rd_addr == A_PTR)  ? DW'(ptr_q) :
                      (rd_addr == A_CNT)  ? DW'(cnt_q) : '0;
  end

  assign rd_data = ch_rd[rd_ch];
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk #(
  parameter int NCH = 2,
  parameter int CW  = 16,
  parameter int DW  = 16,
  parameter int CHW = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [CHW-1:0]  wr_ch,
  input logic [2:0]      wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [NCH-1:0]  xfer_start,
  input logic [NCH-1:0]  en_v,
  input logic [NCH-1:0]  pend_v,
  input logic [NCH-1:0]  busy_v,
  input logic [NCH-1:0]  evt_v,
  input logic [NCH*CW-1:0] cnt_v,
  input logic [NCH*CW-1:0] rld_v
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    wire en_wr = wr_en && wr_ch == CHW'(c) && wr_addr == 3'd0 && wr_data[0];

    p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[c] |-> en_v[c] && pend_v[c] && !busy_v[c]);
    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[c] && !evt_v[c] |=> !pend_v[c]);
    p_one_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start[c] |=> !xfer_start[c]);
    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_v[c] && !evt_v[c] |=> !pend_v[c]);
    p_reload_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr |=> cnt_v[c*CW +: CW] == $past(rld_v[c*CW +: CW]));
    p_evt_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_v[c] |=> pend_v[c]);
  end
endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(.NCH(NCH), .CW(CW), .DW(DW), .CHW(CHW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
  .wr_data(wr_data), .xfer_start(xfer_start), .en_v(en_v), .pend_v(pend_v),
  .busy_v(busy_v), .evt_v(evt_v), .cnt_v(cnt_v), .rld_v(rld_v)
);

// File: tb/dma_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_req_ctrl_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_ch = '0, rd_ch = '0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic [31:0] per_req = '0;
  logic [1:0]  xfer_start, xfer_done = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_ch(rd_ch), .rd_addr(rd_addr), .rd_data(rd_data),
    .per_req(per_req), .xfer_start(xfer_start), .xfer_done(xfer_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = ch[0:0]; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input int a, output logic [15:0] v);
    rd_ch = ch[0:0]; rd_addr = a[2:0];
    #1 v = rd_data;
  endtask

  task automatic pend_is(input int ch, input bit exp, input string req);
    logic [15:0] v;
    rd(ch, 0, v);
    check(req, 32'(v[1]), 32'(exp));
  endtask

  task automatic done_pulse(input int ch);
    @(negedge clk); xfer_done[ch] = 1'b1;
    @(negedge clk); xfer_done[ch] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int a = 0; a < 7; a++) begin
        rd(ch, a, v); check("R1", 32'(v), 0);
      end
    check("R1 start", 32'(xfer_start), 0);

    // R2 / R3 reload
    wr(0, 2, 16'h1000); wr(0, 3, 16'h2000); wr(0, 4, 16'd5);
    wr(0, 0, 16'h5);
    rd(0, 5, v); check("R3 src", 32'(v), 32'h1000);
    rd(0, 6, v); check("R2 cnt", 32'(v), 5);
    wr(0, 0, 16'h9);
    rd(0, 5, v); check("R3 dst", 32'(v), 32'h2000);
    wr(0, 0, 16'h1);
    rd(0, 5, v); check("R3 keep", 32'(v), 32'h2000);
    wr(0, 4, 16'd7); wr(0, 0, 16'h1);
    rd(0, 6, v); check("R2 re-enable", 32'(v), 7);

    // R8 sweep: channel 1 disabled, every code against every line
    for (int s = 1; s < 32; s++) begin
      wr(1, 1, 16'(s)); wr(1, 0, 16'h0);
      for (int l = 0; l < 32; l++) begin
        @(negedge clk); per_req = 32'(1) << l;
        @(negedge clk); per_req = '0;
        pend_is(1, (l == s), "R8 sweep");
        if (l == s) wr(1, 0, 16'h0);
      end
    end
    pend_is(0, 1'b0, "R12 ch0 untouched");
    check("R12 no start", 32'(xfer_start), 0);

    // R8 held high gives one request
    wr(1, 1, 16'd5); wr(1, 0, 16'h0);
    @(negedge clk); per_req[5] = 1'b1;
    repeat (3) @(negedge clk);
    wr(1, 0, 16'h0);
    repeat (3) @(negedge clk);
    pend_is(1, 1'b0, "R8 held");
    per_req = '0;

    // R6 set ignored, clear works; R5 pending held while disabled
    wr(1, 0, 16'h2);
    pend_is(1, 1'b0, "R6 set ignored");
    @(negedge clk); per_req[5] = 1'b1;
    @(negedge clk); per_req = '0;
    repeat (4) @(negedge clk);
    pend_is(1, 1'b1, "R5 held");
    check("R5 no start", 32'(xfer_start[1]), 0);
    wr(1, 0, 16'h2);
    pend_is(1, 1'b1, "R6 one keeps");
    wr(1, 0, 16'h0);
    pend_is(1, 1'b0, "R6 clear");

    // R7 software trigger
    wr(1, 1, 16'h20);
    pend_is(1, 1'b1, "R7 sw");
    rd(1, 1, v); check("R7 readback", 32'(v), 0);
    wr(1, 0, 16'h0);
    wr(1, 1, 16'h23);
    @(negedge clk);
    pend_is(1, 1'b0, "R7 ignored");
    rd(1, 1, v); check("R7 code", 32'(v), 3);

    // R9 selection change onto a high line
    wr(1, 1, 16'd1);
    @(negedge clk); per_req[7] = 1'b1;
    wr(1, 0, 16'h0);
    pend_is(1, 1'b0, "R9 before");
    wr(1, 1, 16'd7);
    @(negedge clk);
    pend_is(1, 1'b1, "R9 spurious");
    per_req = '0; wr(1, 0, 16'h0);

    // R4 / R10 enabled flow on channel 0
    wr(0, 2, 16'h1000); wr(0, 4, 16'd3); wr(0, 0, 16'h5);
    wr(0, 1, 16'h20);
    #1 check("R4 start", 32'(xfer_start), 1);
    @(negedge clk);
    check("R4 strobe low", 32'(xfer_start), 0);
    pend_is(0, 1'b0, "R4 cleared");
    wr(0, 1, 16'h20);
    pend_is(0, 1'b1, "R10 pend while busy");
    check("R10 busy no start", 32'(xfer_start), 0);
    done_pulse(0);
    #1 check("R10 restart", 32'(xfer_start), 1);
    rd(0, 6, v); check("R10 cnt", 32'(v), 2);
    rd(0, 5, v); check("R10 ptr", 32'(v), 32'h1001);
    done_pulse(0);
    rd(0, 6, v); check("R10 cnt2", 32'(v), 1);
    rd(0, 5, v); check("R10 ptr2", 32'(v), 32'h1002);
    pend_is(1, 1'b0, "R12 ch1 untouched");

    // R11 request together with enable + clear write
    wr(0, 1, 16'd2); wr(0, 0, 16'h5);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 1'b0; wr_addr = 3'd0; wr_data = 16'h5; per_req[2] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1 check("R11 start", 32'(xfer_start), 1);
    rd(0, 6, v); check("R11 cnt", 32'(v), 3);
    rd(0, 5, v); check("R11 ptr", 32'(v), 32'h1000);
    per_req = '0;
    done_pulse(0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule